// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a CPU register port and a small one-time-programmable bit array, which is modelled here as a register array that starts blank. Software uses registers to pick a command, a row address and the write data. It then raises a start bit and polls a status register until the done flag appears. When the done flag is seen, software collects any read data and lowers start again before it issues the next command.

Programming stays locked until software runs four unlock commands in a row, each one carrying the next value of a fixed key. A legal program operation can only turn 0 bits into 1. It takes a number of cycles that grows with the count of 1 bits in the row being written, which stands in for the slow fuse-burn time of real silicon. A row holds one or two 32-bit words, and a parameter selects which.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, every register reads 0 (the status register included), and every array row reads back as 0.
- R2: These registers read back what was written, with the unused bits held at 0:
  - mode at 0x00, bit 0 only;
  - command at 0x04, bits 5:0;
  - start at 0x08, bit 0;
  - address at 0x28, bits 15:0;
  - write word 0 at 0x2C and write word 1 at 0x64, all 32 bits.
  Read word 0 sits at 0x10 and read word 1 at 0x5C. Writes to the status register at 0x0C change nothing.
- R3: A command is launched when a write takes start from 0 to 1 while mode bit 0 is 1. When the command finishes, status bit 1 (done) is set and stays set until a write clears start. Done is low again from the edge of that clearing write. If start is cleared in the same cycle that a command finishes, done never rises.
- R4: While mode bit 0 is 0, a start edge is ignored. Done stays 0 and the array is unchanged.
- R5: Command 0x00 (read) copies the row at address bits ADDR_W-1:0 into the read-word registers.
- R6: Status bit 2 (program-OK) is set after four consecutive commands 0x02 whose write word 0 values are 0x0F, 0x04, 0x08 and 0x0D, in that order.
- R7: A wrong value at any unlock step returns the sequence to its first step and leaves program-OK at 0. The whole key must then be entered again from 0x0F.
- R8: Command 0x03 clears program-OK.
- R9: Command 0x08 (program), issued while program-OK is 1, ORs the write words into the addressed row. No stored 1 bit is ever cleared.
- R10: Command 0x08 issued while program-OK is 0 still completes, and it leaves the array unchanged.
- R11: A legal program raises done PROG_BASE + PROG_PER_BIT × (number of 1 bits across the row's write words) + 1 cycles after the start write edge. Every other command raises done 1 cycle after that edge.
- R12: Any command code other than 0x00, 0x02, 0x03 or 0x08 finishes in 1 cycle. It leaves the array, the read words and program-OK unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |

## Verification
The expiry of the program timer and a software write that clears start can land on the same clock edge. When they do, the controller has to commit the burn and also skip the done state. The bench works out the program latency from the bit count of the data and times the clearing write to land exactly on the completion edge. It then checks that status bit 1 stays 0 and that the row holds the ORed data.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam logic [7:0] OFF_MODE   = 8'h00;
  localparam logic [7:0] OFF_CMD    = 8'h04;
  localparam logic [7:0] OFF_START  = 8'h08;
  localparam logic [7:0] OFF_STATUS = 8'h0C;
  localparam logic [7:0] OFF_ADDR   = 8'h28;

  localparam logic [5:0] CMD_READ   = 6'h00;
  localparam logic [5:0] CMD_UNLOCK = 6'h02;
  localparam logic [5:0] CMD_LOCK   = 6'h03;
  localparam logic [5:0] CMD_BURN   = 6'h08;

  localparam int STAT_DONE = 1;
  localparam int STAT_OK   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} otp_state_e;

  function automatic logic [7:0] wdat_off(input int w);
    return (w == 0) ? 8'h2C : 8'h64;
  endfunction

  function automatic logic [7:0] rdat_off(input int w);
    return (w == 0) ? 8'h10 : 8'h5C;
  endfunction

  function automatic logic [31:0] unlock_key(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32'h0F;
      2'd1:    return 32'h04;
      2'd2:    return 32'h08;
      default: return 32'h0D;
    endcase
  endfunction
endpackage

// File: rtl/otp_unlock.sv
module otp_unlock
  import otp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        step_i,
  input  logic [31:0] value_i,
  input  logic        clear_i,
  output logic        ok_o
);
  logic [1:0] stage_q;
  logic       ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      ok_q    <= 1'b0;
    end else if (clear_i) begin
      stage_q <= '0;
      ok_q    <= 1'b0;
    end else if (step_i) begin
      if (value_i == unlock_key(stage_q)) begin
        stage_q <= stage_q + 2'd1;  // wraps to 0 after the last key
        if (stage_q == 2'd3) ok_q <= 1'b1;
      end else begin
        stage_q <= '0;
        ok_q    <= 1'b0;
      end
    end
  end

  assign ok_o = ok_q;

  AST_OK_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> $past(step_i)); // R6
  AST_LOCK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ok_o); // R8
endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int ROW_BITS     = 64,
  parameter int PROG_BASE    = 2,
  parameter int PROG_PER_BIT = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                timed_i,
  input  logic [ROW_BITS-1:0] data_i,
  output logic                fire_o
);
  localparam int MAX_LAT = PROG_BASE + PROG_PER_BIT * ROW_BITS;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      lat_w;

  always_comb lat_w = 32'(PROG_BASE) + 32'(PROG_PER_BIT) * 32'($countones(data_i));

  assign fire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= timed_i ? CNT_W'(lat_w) : '0;
    end else if (fire_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_SINGLE_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R11
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_q); // R11
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int ROW_BITS = 64,
  parameter int ADDR_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                burn_i,
  input  logic [ADDR_W-1:0]   burn_addr_i,
  input  logic [ROW_BITS-1:0] burn_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [ROW_BITS-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ROW_BITS-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (burn_i) begin
      mem_q[burn_addr_i] <= mem_q[burn_addr_i] | burn_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  AST_NO_BIT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_addr_i) |-> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o))); // R9
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int ROW_WORDS    = 2,
  parameter int ADDR_W       = 3,
  parameter int PROG_BASE    = 2,
  parameter int PROG_PER_BIT = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int ROW_BITS = 32 * ROW_WORDS;

  logic                           mode_q, start_q, start_nxt;
  logic [5:0]                     cmd_q, act_cmd_q;
  logic [15:0]                    addr_q;
  logic [ADDR_W-1:0]              act_addr_q;
  logic [ROW_WORDS-1:0][31:0]     wdat_q, rdat_q;
  logic [ROW_BITS-1:0]            act_data_q, row_rd;
  otp_state_e                     state_q;
  logic                           wr, wr_start, launch, fire, prog_ok, burn, rd_fire;

  assign wr        = req_i && we_i;
  assign wr_start  = wr && (addr_i == OFF_START);
  assign start_nxt = wr_start ? wdata_i[0] : start_q;
  assign launch    = wr_start && wdata_i[0] && !start_q && mode_q && (state_q == ST_IDLE);
  assign burn      = fire && (act_cmd_q == CMD_BURN) && prog_ok;
  assign rd_fire   = fire && (act_cmd_q == CMD_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      cmd_q   <= '0;
      start_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      start_q <= start_nxt;
      if (wr && addr_i == OFF_MODE) mode_q <= wdata_i[0];
      if (wr && addr_i == OFF_CMD)  cmd_q  <= wdata_i[5:0];
      if (wr && addr_i == OFF_ADDR) addr_q <= wdata_i[15:0];
    end
  end

  for (genvar w = 0; w < ROW_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wdat_q[w] <= '0;
        rdat_q[w] <= '0;
      end else begin
        if (wr && addr_i == wdat_off(w)) wdat_q[w] <= wdata_i;
        if (rd_fire) rdat_q[w] <= row_rd[w*32 +: 32];
      end
    end
  end

  // command context latched at launch so later register writes cannot disturb it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      act_cmd_q  <= '0;
      act_addr_q <= '0;
      act_data_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q    <= ST_BUSY;
          act_cmd_q  <= cmd_q;
          act_addr_q <= addr_q[ADDR_W-1:0];
          act_data_q <= wdat_q;
        end
        ST_BUSY: if (fire) state_q <= start_nxt ? ST_DONE : ST_IDLE;
        default: if (!start_nxt) state_q <= ST_IDLE;
      endcase
    end
  end

  otp_prog_timer #(
    .ROW_BITS(ROW_BITS), .PROG_BASE(PROG_BASE), .PROG_PER_BIT(PROG_PER_BIT)
  ) u_timer (
    .clk_i, .rst_ni,
    .load_i (launch),
    .timed_i((cmd_q == CMD_BURN) && prog_ok),
    .data_i (wdat_q),
    .fire_o (fire)
  );

  otp_unlock u_unlock (
    .clk_i, .rst_ni,
    .step_i (fire && act_cmd_q == CMD_UNLOCK),
    .value_i(act_data_q[31:0]),
    .clear_i(fire && act_cmd_q == CMD_LOCK),
    .ok_o   (prog_ok)
  );

  otp_array #(.ROW_BITS(ROW_BITS), .ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .burn_i     (burn),
    .burn_addr_i(act_addr_q),
    .burn_data_i(act_data_q),
    .rd_addr_i  (act_addr_q),
    .rd_data_o  (row_rd)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_MODE:   rdata_o = {31'b0, mode_q};
      OFF_CMD:    rdata_o = {26'b0, cmd_q};
      OFF_START:  rdata_o = {31'b0, start_q};
      OFF_STATUS: rdata_o = {29'b0, prog_ok, (state_q == ST_DONE), 1'b0};
      OFF_ADDR:   rdata_o = {16'b0, addr_q};
      default:    rdata_o = '0;
    endcase
    for (int w = 0; w < ROW_WORDS; w++) begin
      if (addr_i == wdat_off(w)) rdata_o = wdat_q[w];
      if (addr_i == rdat_off(w)) rdata_o = rdat_q[w];
    end
  end

  AST_DONE_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |-> start_q); // R3
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && state_q == ST_IDLE) |=> (state_q == ST_IDLE)); // R4
endmodule

// File: tb/tb_otp_ctrl.sv
module tb_otp_ctrl;
  localparam int ROWS = 8, BASE = 2, PER = 1;
  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08, A_STAT = 8'h0C,
    A_ADDR = 8'h28, A_W0 = 8'h2C, A_W1 = 8'h64, A_R0 = 8'h10, A_R1 = 8'h5C;

  logic clk = 0, rst_ni = 0, req = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  logic [31:0] mdl0 [ROWS];
  logic [31:0] mdl1 [ROWS];

  always #10 clk = ~clk;

  otp_ctrl dut (.clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we),
                .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic launch(input logic [5:0] c, input logic [15:0] a,
                        input logic [31:0] d0, input logic [31:0] d1);
    wr(A_CMD, {26'b0, c}); wr(A_ADDR, {16'b0, a}); wr(A_W0, d0); wr(A_W1, d1);
    wr(A_START, 1);
  endtask

  task automatic poll(output int n);
    logic [31:0] s;
    n = 0;
    rd(A_STAT, s);
    while (!s[1] && n < 300) begin
      @(negedge clk); n++; rd(A_STAT, s);
    end
  endtask

  task automatic run(input logic [5:0] c, input logic [15:0] a,
                     input logic [31:0] d0, input logic [31:0] d1, output int n);
    launch(c, a, d0, d1); poll(n);
  endtask

  task automatic read_row(input int r, output logic [31:0] q0, output logic [31:0] q1);
    int n;
    run(6'h00, 16'(r), 0, 0, n);
    check("R11 read latency", n, 1);
    rd(A_R0, q0); rd(A_R1, q1);
    wr(A_START, 0);
  endtask

  task automatic ok_is(input string r, input logic e);
    logic [31:0] s;
    rd(A_STAT, s);
    check(r, {31'b0, s[2]}, {31'b0, e});
  endtask

  task automatic unlock_step(input logic [31:0] v);
    int n;
    run(6'h02, 0, v, 0, n);
    wr(A_START, 0);
  endtask

  task automatic burn(input int r, input logic [31:0] d0, input logic [31:0] d1, input logic ok);
    int n, lat;
    lat = ok ? BASE + PER * ($countones(d0) + $countones(d1)) : 0;
    run(6'h08, 16'(r), d0, d1, n);
    check("R11 program latency", n, lat + 1);
    wr(A_START, 0);
    if (ok) begin mdl0[r] |= d0; mdl1[r] |= d1; end
  endtask

  task automatic check_all(input string r);
    logic [31:0] q0, q1;
    for (int i = 0; i < ROWS; i++) begin
      read_row(i, q0, q1);
      check(r, q0, mdl0[i]);
      check(r, q1, mdl1[i]);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, q0, q1, keep;
    int n, lat;
    for (int i = 0; i < ROWS; i++) begin mdl0[i] = 0; mdl1[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset values
    rd(A_MODE, v);  check("R1 mode", v, 0);
    rd(A_CMD, v);   check("R1 cmd", v, 0);
    rd(A_START, v); check("R1 start", v, 0);
    rd(A_STAT, v);  check("R1 status", v, 0);
    rd(A_ADDR, v);  check("R1 addr", v, 0);
    rd(A_W0, v);    check("R1 wdat0", v, 0);
    rd(A_W1, v);    check("R1 wdat1", v, 0);
    rd(A_R0, v);    check("R1 rdat0", v, 0);
    rd(A_R1, v);    check("R1 rdat1", v, 0);

    // R2 register map
    wr(A_MODE, 32'hFFFF_FFFE); rd(A_MODE, v); check("R2 mode bit0", v, 0);
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, v); check("R2 mode", v, 1);
    wr(A_CMD, 32'hFF);         rd(A_CMD, v);  check("R2 cmd mask", v, 32'h3F);
    wr(A_ADDR, 32'h0001_2345); rd(A_ADDR, v); check("R2 addr mask", v, 32'h2345);
    wr(A_W0, 32'hDEAD_BEEF);   rd(A_W0, v);   check("R2 wdat0", v, 32'hDEAD_BEEF);
    wr(A_W1, 32'h1234_5678);   rd(A_W1, v);   check("R2 wdat1", v, 32'h1234_5678);
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); check("R2 status write ignored", v, 0);

    // R4 start ignored with mode off
    wr(A_MODE, 0);
    launch(6'h00, 0, 0, 0);
    repeat (5) @(negedge clk);
    rd(A_STAT, v); check("R4 no done when mode off", v, 0);
    wr(A_START, 0);
    wr(A_MODE, 1);

    // R1 R5 blank array, read of every row
    check_all("R1 R5 blank row");

    // R10 program while locked
    burn(3, 32'hFFFF_0000, 32'h0000_00FF, 0);
    check_all("R10 locked program no change");

    // R7 wrong values restart the sequence
    unlock_step(32'h0F); unlock_step(32'h04); unlock_step(32'h07);
    ok_is("R7 bad third value", 0);
    unlock_step(32'h08); unlock_step(32'h0D);
    ok_is("R7 no resume after error", 0);
    unlock_step(32'h0F); unlock_step(32'h04); unlock_step(32'h08); unlock_step(32'h0F);
    ok_is("R7 bad fourth value", 0);
    // R6 full key
    unlock_step(32'h0F); ok_is("R6 step1", 0);
    unlock_step(32'h04); ok_is("R6 step2", 0);
    unlock_step(32'h08); ok_is("R6 step3", 0);
    unlock_step(32'h0D); ok_is("R6 unlocked", 1);

    // R9 R11 two passes over all rows, OR accumulation
    for (int r = 0; r < ROWS; r++)
      burn(r, 32'hFFFF_FFFF >> (r * 4), 32'h0F0F_0000 ^ (32'h1111_1111 * r), 1);
    burn(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    for (int r = 0; r < ROWS; r++)
      burn(r, 32'hA5A5_A5A5 >> r, 32'h8000_0001 << r, 1);
    check_all("R9 OR accumulate");

    // R3 done holds until start cleared
    run(6'h00, 2, 0, 0, n);
    repeat (4) @(negedge clk);
    rd(A_STAT, v); check("R3 done held", {31'b0, v[1]}, 1);
    wr(A_START, 0);
    rd(A_STAT, v); check("R3 done cleared", {31'b0, v[1]}, 0);

    // R12 undefined codes
    read_row(1, keep, q1);
    for (int c = 0; c < 64; c++) begin
      if (c == 0 || c == 2 || c == 3 || c == 8) continue;
      run(6'(c), 16'(c % ROWS), 32'hFFFF_FFFF, 32'hFFFF_FFFF, n);
      check("R12 undefined code latency", n, 1);
      rd(A_R0, v); check("R12 read word untouched", v, keep);
      wr(A_START, 0);
    end
    ok_is("R12 program-OK kept", 1);
    check_all("R12 array untouched");

    // R3 start cleared on the completion edge of a program
    lat = BASE + PER * ($countones(32'h0000_F000) + $countones(32'h00F0_0000));
    launch(6'h08, 5, 32'h0000_F000, 32'h00F0_0000);
    repeat (lat) @(negedge clk);
    wr(A_START, 0);
    rd(A_STAT, v); check("R3 done suppressed on same-edge clear", {31'b0, v[1]}, 0);
    repeat (3) @(negedge clk);
    rd(A_STAT, v); check("R3 done stays low", {31'b0, v[1]}, 0);
    mdl0[5] |= 32'h0000_F000; mdl1[5] |= 32'h00F0_0000;
    read_row(5, q0, q1);
    check("R3 R9 burn committed word0", q0, mdl0[5]);
    check("R3 R9 burn committed word1", q1, mdl1[5]);

    // R8 relock, then R10 again
    run(6'h03, 0, 0, 0, n); wr(A_START, 0);
    ok_is("R8 locked", 0);
    burn(6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    check_all("R10 relocked program no change");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule